// File: doc/BRIEF.md
# Ingress VLAN Classifier and Filter

This block sits on one port's receive path, after a header parser. For each parsed header it decides which VLAN the frame belongs to, how many leading VLAN tags the rewriter should strip, and whether the frame must be discarded. The parser hands over the source MAC address and up to two tag slots, outer first. Each slot carries a present flag and the tag's type field. The outer slot also carries its 12-bit VLAN identifier.

Per-port configuration sets the behaviour. It supplies a default VID, a VLAN-awareness enable, a requested tag-strip count and four discard enables. The discard enables cover multicast source addresses, untagged frames, priority C-tagged frames and priority S-tagged frames. A port that is not VLAN-aware ignores tags completely. An aware port takes the VID from a recognised outer tag. It can also be set to refuse frames that carry no usable VID when its default VID is zero. Each header produces one registered result one clock later. Table lookup and the payload path belong to other blocks.

Top module: `vlan_ingress_classifier`

## Requirements
- R1: A result is produced exactly one clock after `hdr_valid` is sampled high; `res_valid` is high for that one cycle only, and after reset `res_valid`, `res_vid`, `res_pop` and `res_drop` are all 0.
- R2: When `cfg_aware` is 0, the tag slots have no effect: `res_vid` equals `cfg_pvid` and `res_pop` is 0.
- R3: When `cfg_aware` is 1, the outer slot is present, its type is 0x8100 (C-tag) or 0x88A8 (S-tag) and its VID is non-zero, `res_vid` equals that VID.
- R4: When `cfg_aware` is 1 and the outer slot is absent, carries any other type, or carries VID 0 (a priority tag), `res_vid` equals `cfg_pvid` (which may be 0).
- R5: A slot counts as recognised when it is present and its type is 0x8100 or 0x88A8. Tag depth is the number of consecutive recognised slots counted from the outer one (0 to 2). `res_pop` is min(`cfg_pop_cnt`, depth) when aware, and 0 otherwise.
- R6: A frame whose source MAC has bit 40 set (bit 0 of the first transmitted octet, `hdr_smac[47:40]`) is dropped when `cfg_drop_mc_smac` is 1, whatever the awareness setting.
- R7: When aware, `cfg_pvid` is 0 and `cfg_drop_untag` is 1, a frame whose outer slot is not recognised is dropped.
- R8: When aware, `cfg_pvid` is 0 and `cfg_drop_prio_c` is 1, a frame whose outer tag has type 0x8100 and VID 0 is dropped.
- R9: When aware, `cfg_pvid` is 0 and `cfg_drop_prio_s` is 1, a frame whose outer tag has type 0x88A8 and VID 0 is dropped.
- R10: In cycles after `hdr_valid` is sampled low, `res_vid`, `res_pop` and `res_drop` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Parsed header present this cycle |
| hdr_smac | input | 48 | Source MAC, first octet in bits 47:40 |
| hdr_tag_vld | input | 2 | Tag slot present flags, bit 0 is the outer slot |
| hdr_tag_tpid | input | 32 | Tag type fields, outer slot in bits 15:0 |
| hdr_outer_vid | input | 12 | VID of the outer tag slot |
| cfg_pvid | input | 12 | Port default VID |
| cfg_aware | input | 1 | VLAN-awareness enable |
| cfg_pop_cnt | input | 2 | Requested number of tags to strip |
| cfg_drop_mc_smac | input | 1 | Discard frames with multicast source MAC |
| cfg_drop_untag | input | 1 | Discard untagged frames (aware, default VID 0) |
| cfg_drop_prio_c | input | 1 | Discard priority C-tagged frames (aware, default VID 0) |
| cfg_drop_prio_s | input | 1 | Discard priority S-tagged frames (aware, default VID 0) |
| res_valid | output | 1 | Result valid |
| res_vid | output | 12 | Classified VID |
| res_pop | output | 2 | Number of tags to strip |
| res_drop | output | 1 | Discard decision |

## Verification
The multicast-source discard and the tag-based discards can both fire in the same cycle. The classification and the discard can also disagree: a priority tag falls back to the default VID while the same frame is marked for discard. The bench sweeps every combination of awareness, default VID of zero or non-zero, outer and inner slot kind, outer VID of zero or non-zero, strip count, source address kind and all sixteen discard-enable settings. So a multicast source always meets each tag-rule state, and every result field is compared against an arithmetic model. Each failing discard check names the rule that should have fired.

// File: rtl/vlan_cls_pkg.sv
package vlan_cls_pkg;

  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_CTAG  = 2'd1,
    TAG_STAG  = 2'd2,
    TAG_OTHER = 2'd3
  } tag_kind_e;

  function automatic logic kind_recognised(input tag_kind_e k);
    return (k == TAG_CTAG) || (k == TAG_STAG);
  endfunction

endpackage

// File: rtl/vlan_tag_recog.sv
module vlan_tag_recog
  import vlan_cls_pkg::*;
#(
  parameter int unsigned             TPID_W = 16,
  parameter logic [TPID_W-1:0]       C_TPID = 16'h8100,
  parameter logic [TPID_W-1:0]       S_TPID = 16'h88A8
) (
  input  logic              tag_vld,
  input  logic [TPID_W-1:0] tag_tpid,
  output tag_kind_e         tag_kind
);

  always_comb begin
    if (!tag_vld) begin
      tag_kind = TAG_NONE;
    end else if (tag_tpid == C_TPID) begin
      tag_kind = TAG_CTAG;
    end else if (tag_tpid == S_TPID) begin
      tag_kind = TAG_STAG;
    end else begin
      tag_kind = TAG_OTHER;
    end
  end

endmodule

// File: rtl/vlan_vid_select.sv
module vlan_vid_select
  import vlan_cls_pkg::*;
#(
  parameter int unsigned VID_W = 12
) (
  input  logic             aware,
  input  tag_kind_e        outer_kind,
  input  logic [VID_W-1:0] outer_vid,
  input  logic [VID_W-1:0] pvid,
  output logic [VID_W-1:0] cls_vid,
  output logic             outer_recog,
  output logic             prio_ctag,
  output logic             prio_stag
);

  logic vid_zero;
  logic use_tag;

  always_comb begin
    outer_recog = kind_recognised(outer_kind);
    vid_zero    = (outer_vid == '0);
    use_tag     = aware && outer_recog && !vid_zero;
    cls_vid     = use_tag ? outer_vid : pvid;
    prio_ctag   = aware && (outer_kind == TAG_CTAG) && vid_zero;
    prio_stag   = aware && (outer_kind == TAG_STAG) && vid_zero;
  end

endmodule

// File: rtl/vlan_drop_eval.sv
module vlan_drop_eval (
  input  logic aware,
  input  logic pvid_zero,
  input  logic mc_src,
  input  logic outer_recog,
  input  logic prio_ctag,
  input  logic prio_stag,
  input  logic en_mc_src,
  input  logic en_untag,
  input  logic en_prio_c,
  input  logic en_prio_s,
  output logic drop
);

  logic strict_port;
  logic tag_rule_hit;

  always_comb begin
    strict_port  = aware && pvid_zero;
    tag_rule_hit = (en_untag  && !outer_recog) ||
                   (en_prio_c && prio_ctag)    ||
                   (en_prio_s && prio_stag);
    drop         = (en_mc_src && mc_src) || (strict_port && tag_rule_hit);
  end

endmodule

// File: rtl/vlan_ingress_classifier.sv
module vlan_ingress_classifier
  import vlan_cls_pkg::*;
#(
  parameter int unsigned       MAC_W    = 48,
  parameter int unsigned       VID_W    = 12,
  parameter int unsigned       TPID_W   = 16,
  parameter int unsigned       NUM_TAGS = 2,
  parameter int unsigned       POP_W    = 2,
  parameter logic [TPID_W-1:0] C_TPID   = 16'h8100,
  parameter logic [TPID_W-1:0] S_TPID   = 16'h88A8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  input  logic [MAC_W-1:0]           hdr_smac,
  input  logic [NUM_TAGS-1:0]        hdr_tag_vld,
  input  logic [NUM_TAGS*TPID_W-1:0] hdr_tag_tpid,
  input  logic [VID_W-1:0]           hdr_outer_vid,
  input  logic [VID_W-1:0]           cfg_pvid,
  input  logic                       cfg_aware,
  input  logic [POP_W-1:0]           cfg_pop_cnt,
  input  logic                       cfg_drop_mc_smac,
  input  logic                       cfg_drop_untag,
  input  logic                       cfg_drop_prio_c,
  input  logic                       cfg_drop_prio_s,
  output logic                       res_valid,
  output logic [VID_W-1:0]           res_vid,
  output logic [POP_W-1:0]           res_pop,
  output logic                       res_drop
);

  localparam int unsigned MC_BIT  = MAC_W - 8;
  localparam int unsigned DEPTH_W = $clog2(NUM_TAGS + 1);
  localparam int unsigned CMP_W   = (POP_W > DEPTH_W) ? POP_W : DEPTH_W;

  tag_kind_e            tag_kind [NUM_TAGS];
  logic [NUM_TAGS:0]    run_chain;
  logic [DEPTH_W-1:0]   tag_depth;
  logic [CMP_W-1:0]     depth_ext;
  logic [CMP_W-1:0]     req_ext;
  logic [POP_W-1:0]     pop_nxt;
  logic [VID_W-1:0]     vid_nxt;
  logic                 drop_nxt;
  logic                 outer_recog;
  logic                 prio_ctag;
  logic                 prio_stag;
  logic                 valid_nxt;

  // One recogniser per tag slot
  assign run_chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    vlan_tag_recog #(
      .TPID_W (TPID_W),
      .C_TPID (C_TPID),
      .S_TPID (S_TPID)
    ) u_recog (
      .tag_vld  (hdr_tag_vld[g]),
      .tag_tpid (hdr_tag_tpid[g*TPID_W +: TPID_W]),
      .tag_kind (tag_kind[g])
    );
    assign run_chain[g+1] = run_chain[g] && kind_recognised(tag_kind[g]);
  end

  // Depth of consecutive recognised tags from the outer slot
  always_comb begin
    tag_depth = '0;
    for (int i = 1; i <= NUM_TAGS; i++) begin
      if (run_chain[i]) begin
        tag_depth = tag_depth + DEPTH_W'(1);
      end
    end
  end

  // Strip count: requested count clamped to the recognised depth
  always_comb begin
    depth_ext = CMP_W'(tag_depth);
    req_ext   = CMP_W'(cfg_pop_cnt);
    if (!cfg_aware) begin
      pop_nxt = '0;
    end else if (req_ext < depth_ext) begin
      pop_nxt = cfg_pop_cnt;
    end else begin
      pop_nxt = POP_W'(depth_ext);
    end
  end

  vlan_vid_select #(
    .VID_W (VID_W)
  ) u_vid (
    .aware       (cfg_aware),
    .outer_kind  (tag_kind[0]),
    .outer_vid   (hdr_outer_vid),
    .pvid        (cfg_pvid),
    .cls_vid     (vid_nxt),
    .outer_recog (outer_recog),
    .prio_ctag   (prio_ctag),
    .prio_stag   (prio_stag)
  );

  vlan_drop_eval u_drop (
    .aware       (cfg_aware),
    .pvid_zero   (cfg_pvid == '0),
    .mc_src      (hdr_smac[MC_BIT]),
    .outer_recog (outer_recog),
    .prio_ctag   (prio_ctag),
    .prio_stag   (prio_stag),
    .en_mc_src   (cfg_drop_mc_smac),
    .en_untag    (cfg_drop_untag),
    .en_prio_c   (cfg_drop_prio_c),
    .en_prio_s   (cfg_drop_prio_s),
    .drop        (drop_nxt)
  );

  assign valid_nxt = hdr_valid;

  // Result registers; data loaded only when a header is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vid  <= '0;
      res_pop  <= '0;
      res_drop <= 1'b0;
    end else if (hdr_valid) begin
      res_vid  <= vid_nxt;
      res_pop  <= pop_nxt;
      res_drop <= drop_nxt;
    end
  end

endmodule

// File: rtl/vlan_cls_checker.sv
module vlan_cls_checker #(
  parameter int unsigned       MAC_W  = 48,
  parameter int unsigned       VID_W  = 12,
  parameter int unsigned       TPID_W = 16,
  parameter int unsigned       POP_W  = 2,
  parameter logic [TPID_W-1:0] C_TPID = 16'h8100,
  parameter logic [TPID_W-1:0] S_TPID = 16'h88A8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic [MAC_W-1:0]  hdr_smac,
  input logic [1:0]        hdr_tag_vld,
  input logic [2*TPID_W-1:0] hdr_tag_tpid,
  input logic [VID_W-1:0]  hdr_outer_vid,
  input logic [VID_W-1:0]  cfg_pvid,
  input logic              cfg_aware,
  input logic [POP_W-1:0]  cfg_pop_cnt,
  input logic              cfg_drop_mc_smac,
  input logic              cfg_drop_untag,
  input logic              cfg_drop_prio_c,
  input logic              cfg_drop_prio_s,
  input logic              res_valid,
  input logic [VID_W-1:0]  res_vid,
  input logic [POP_W-1:0]  res_pop,
  input logic              res_drop
);

  logic [TPID_W-1:0] outer_tpid;
  logic              strict_port;
  assign outer_tpid  = hdr_tag_tpid[TPID_W-1:0];
  assign strict_port = cfg_aware && (cfg_pvid == '0);

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid);

  a_r2_unaware_default: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !cfg_aware) |=> (res_vid == $past(cfg_pvid)) && (res_pop == '0));

  a_r3_tag_vid: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_aware && hdr_tag_vld[0] && (hdr_outer_vid != '0) &&
     ((outer_tpid == C_TPID) || (outer_tpid == S_TPID)))
    |=> (res_vid == $past(hdr_outer_vid)));

  a_r5_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (res_pop <= $past(cfg_pop_cnt)));

  a_r6_mc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_drop_mc_smac && hdr_smac[MAC_W-8]) |=> res_drop);

  a_r7_untag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && strict_port && cfg_drop_untag && !hdr_tag_vld[0]) |=> res_drop);

  a_r8_prio_c_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && strict_port && cfg_drop_prio_c && hdr_tag_vld[0] &&
     (outer_tpid == C_TPID) && (hdr_outer_vid == '0)) |=> res_drop);

  a_r9_prio_s_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && strict_port && cfg_drop_prio_s && hdr_tag_vld[0] &&
     (outer_tpid == S_TPID) && (hdr_outer_vid == '0)) |=> res_drop);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(res_vid) && $stable(res_pop) && $stable(res_drop)));

endmodule

bind vlan_ingress_classifier vlan_cls_checker #(
  .MAC_W  (MAC_W),
  .VID_W  (VID_W),
  .TPID_W (TPID_W),
  .POP_W  (POP_W),
  .C_TPID (C_TPID),
  .S_TPID (S_TPID)
) u_vlan_cls_checker (.*);

// File: tb/tb_vlan_ingress_classifier.sv
`timescale 1ns/1ps
module tb_vlan_ingress_classifier;

  logic        clk;
  logic        rst_n;
  logic        hdr_valid;
  logic [47:0] hdr_smac;
  logic [1:0]  hdr_tag_vld;
  logic [31:0] hdr_tag_tpid;
  logic [11:0] hdr_outer_vid;
  logic [11:0] cfg_pvid;
  logic        cfg_aware;
  logic [1:0]  cfg_pop_cnt;
  logic        cfg_drop_mc_smac;
  logic        cfg_drop_untag;
  logic        cfg_drop_prio_c;
  logic        cfg_drop_prio_s;
  logic        res_valid;
  logic [11:0] res_vid;
  logic [1:0]  res_pop;
  logic        res_drop;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vlan_ingress_classifier dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // slot kind code: 0 absent, 1 C-tag, 2 S-tag, 3 other type
  function automatic logic [15:0] kind_tpid(input int k);
    case (k)
      1: return 16'h8100;
      2: return 16'h88A8;
      3: return 16'h9100;
      default: return 16'h8100;
    endcase
  endfunction

  task automatic run_vec(input int aw, input int pv, input int k0, input int v0,
                         input int k1, input int pc, input int mc, input int en);
    int  exp_vid, exp_pop, depth;
    bit  r0, r1, strict, exp_drop;
    string vreq, dreq;
    r0 = (k0 == 1) || (k0 == 2);
    r1 = r0 && ((k1 == 1) || (k1 == 2));
    depth = int'(r0) + int'(r1);
    exp_pop = aw ? ((pc < depth) ? pc : depth) : 0;
    exp_vid = (aw && r0 && v0 != 0) ? v0 : pv;
    vreq = !aw ? "R2" : ((r0 && v0 != 0) ? "R3" : "R4");
    strict = aw && (pv == 0);
    exp_drop = 1'b0;
    dreq = "R6 R7 R8 R9 no rule";
    if (strict && en[1] && !r0)             begin exp_drop = 1; dreq = "R7"; end
    if (strict && en[2] && k0 == 1 && v0 == 0) begin exp_drop = 1; dreq = "R8"; end
    if (strict && en[3] && k0 == 2 && v0 == 0) begin exp_drop = 1; dreq = "R9"; end
    if (en[0] && mc != 0)                   begin exp_drop = 1; dreq = "R6"; end

    @(negedge clk);
    hdr_valid        = 1'b1;
    cfg_aware        = aw[0];
    cfg_pvid         = 12'(pv);
    cfg_pop_cnt      = 2'(pc);
    hdr_tag_vld      = {1'(k1 != 0), 1'(k0 != 0)};
    hdr_tag_tpid     = {kind_tpid(k1), kind_tpid(k0)};
    hdr_outer_vid    = 12'(v0);
    hdr_smac         = (mc != 0) ? 48'h0300_1122_3344 : 48'h0200_1122_3344;
    cfg_drop_mc_smac = en[0];
    cfg_drop_untag   = en[1];
    cfg_drop_prio_c  = en[2];
    cfg_drop_prio_s  = en[3];
    @(negedge clk);
    hdr_valid = 1'b0;
    check(res_valid == 1'b1, "R1 valid", int'(res_valid), 1);
    check(res_vid == 12'(exp_vid), vreq, int'(res_vid), exp_vid);
    check(res_pop == 2'(exp_pop), "R5", int'(res_pop), exp_pop);
    check(res_drop == exp_drop, dreq, int'(res_drop), int'(exp_drop));
    // disturb inputs while idle; results must not move
    cfg_pvid      = 12'hABC;
    cfg_aware     = ~cfg_aware;
    hdr_outer_vid = 12'h555;
    hdr_smac      = ~hdr_smac;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 single cycle", int'(res_valid), 0);
    check((res_vid == 12'(exp_vid)) && (res_pop == 2'(exp_pop)) && (res_drop == exp_drop),
          "R10 hold", int'(res_vid), exp_vid);
  endtask

  initial begin
    rst_n = 1'b0;
    hdr_valid = 1'b0; hdr_smac = '0; hdr_tag_vld = '0; hdr_tag_tpid = '0;
    hdr_outer_vid = '0; cfg_pvid = '0; cfg_aware = 1'b0; cfg_pop_cnt = '0;
    cfg_drop_mc_smac = 1'b0; cfg_drop_untag = 1'b0;
    cfg_drop_prio_c = 1'b0; cfg_drop_prio_s = 1'b0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
    check(res_vid == '0 && res_pop == '0 && res_drop == 1'b0, "R1 reset data",
          int'(res_vid), 0);
    rst_n = 1'b1;
    for (int aw = 0; aw < 2; aw++)
      for (int pz = 0; pz < 2; pz++)
        for (int k0 = 0; k0 < 4; k0++)
          for (int vz = 0; vz < 2; vz++)
            for (int k1 = 0; k1 < 4; k1++)
              for (int pc = 0; pc < 4; pc++)
                for (int mc = 0; mc < 2; mc++)
                  for (int en = 0; en < 16; en++)
                    run_vec(aw, pz ? 5 : 0, k0, vz ? 7 : 0, k1, pc, mc, en);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule